// File: doc/BRIEF.md
# SPI Register Access Slave (32-bit frames)

This block connects an external SPI master to an on-chip register bus. Each transaction is one 32-bit frame. Bit 31 is a direction flag: 1 for a write, 0 for a read. Bits 30:25 hold a 6-bit register index. Bits 23:0 hold 24 bits of register data. Bit 24 is a spare bit that the block does not use.

The serial lines are brought into the system clock domain through short synchronizer chains. The SPI clock is sampled there and its edges are detected, so the SPI clock must run several times slower than the system clock.

For a write, the block waits until chip select drops. It then issues a one-cycle write strobe with the index and data, but only if exactly 32 SPI clocks were seen in the frame. For a read, the block issues a one-cycle read strobe as soon as the first seven bits have arrived. It captures the register value from the bus and shifts it back on MISO, MSB first, as the low 24 bits of the same frame.

Top module: `spi_regslave`

## Requirements
- R1: After reset, `reg_wr_stb`, `reg_rd_stb` and `spi_miso` are all 0.
- R2: A frame of exactly 32 SCLK rising edges with bit 31 = 1 produces exactly one `reg_wr_stb` pulse after chip select falls. During that pulse, `reg_addr` equals frame bits 30:25 and `reg_wdata` equals frame bits 23:0.
- R3: A frame with bit 31 = 0 produces one `reg_rd_stb` pulse, with `reg_addr` equal to frame bits 30:25. The value on `reg_rdata` during that pulse is returned on MISO, MSB first, in frame bits 23:0.
- R4: MISO is 0 during frame bits 31:24 of every frame. It is also 0 whenever chip select has been low for more than three system clocks.
- R5: A write frame with any count of SCLK rising edges other than 32 (both shorter and longer) produces no write strobe.
- R6: Frame bit 24 has no effect. A write with bit 24 = 1 stores the same data as one with bit 24 = 0.
- R7: A read frame never produces a write strobe, and a write frame never produces a read strobe. The two strobes are never high together.
- R8: SCLK edges while chip select is low are ignored. They cause no strobe, and the next frame decodes correctly.
- R9: Each strobe is high for exactly one system clock cycle per event.
- R10: SPI mode 0 with an active-high chip select. MOSI is sampled on SCLK rising edges. MISO changes only after SCLK falling edges or at frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_addr | output | ADDR_W (6) | Register index for the current strobe |
| reg_wr_stb | output | 1 | One-cycle write strobe |
| reg_wdata | output | DATA_W (24) | Write data, valid with `reg_wr_stb` |
| reg_rd_stb | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W (24) | Register value, sampled during `reg_rd_stb` |

## Verification
Some properties are checked by assertions on every cycle:
- the strobes are single-cycle and mutually exclusive;
- MISO is quiet while chip select has been low and while the read strobe is high;
- the register index holds still across the cycle after a read strobe.

Other behaviour can only be shown by the bench's scenarios, because it depends on whole frames:
- the 32-clock length rule;
- correct index and data extraction;
- MSB-first return of read data in the low 24 bits;
- ignoring of the spare bit and of SCLK activity outside a frame.

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_stb,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_stb,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int FRAME_W = 2 + ADDR_W + DATA_W;
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_DSTRT = CNT_W'(FRAME_W - DATA_W);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic sclk_d, cs_d;
  logic sclk_s, cs_s, mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '0;
      mosi_sync <= '0;
      sclk_d    <= 1'b0;
      cs_d      <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], spi_sclk};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], spi_cs};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], spi_mosi};
      sclk_d    <= sclk_sync[SYNC_STAGES-1];
      cs_d      <= cs_sync[SYNC_STAGES-1];
    end
  end

  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign cs_s   = cs_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire cs_rise   = cs_s & ~cs_d;
  wire cs_fall   = ~cs_s & cs_d;

  logic [FRAME_W-1:0] rx;
  logic [DATA_W-1:0]  tx;
  logic [CNT_W-1:0]   cnt;
  logic               miso_q, rd_q, wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;

  wire frame_ok = (cnt == CNT_FULL) & rx[FRAME_W-1];
  wire hdr_done = sclk_rise & (cnt == CNT_HDR);
  wire in_data  = (cnt >= CNT_DSTRT) & (cnt < CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx      <= '0;
      tx      <= '0;
      cnt     <= '0;
      miso_q  <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      if (cs_rise) begin
        rx     <= '0;
        tx     <= '0;
        cnt    <= '0;
        miso_q <= 1'b0;
      end else if (!cs_s) begin
        miso_q <= 1'b0;
        if (cs_fall && frame_ok) begin
          wr_q    <= 1'b1;
          addr_q  <= rx[FRAME_W-2 -: ADDR_W];
          wdata_q <= rx[DATA_W-1:0];
        end
      end else begin
        if (sclk_rise) begin
          rx <= {rx[FRAME_W-2:0], mosi_s};
          if (cnt <= CNT_FULL) cnt <= cnt + 1'b1;
        end
        if (hdr_done && !rx[HDR_W-2]) begin
          rd_q   <= 1'b1;
          addr_q <= {rx[ADDR_W-2:0], mosi_s};
        end
        if (rd_q) tx <= reg_rdata;
        if (sclk_fall) begin
          if (in_data) begin
            miso_q <= tx[DATA_W-1];
            tx     <= {tx[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  assign spi_miso   = miso_q;
  assign reg_rd_stb = rd_q;
  assign reg_wr_stb = wr_q;
  assign reg_addr   = addr_q;
  assign reg_wdata  = wdata_q;

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs,
  input logic              spi_miso,
  input logic              reg_rd_stb,
  input logic              reg_wr_stb,
  input logic [ADDR_W-1:0] reg_addr
);

  a_r9_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> !reg_wr_stb);

  a_r9_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |=> !reg_rd_stb);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_stb && reg_wr_stb));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs && !$past(spi_cs) && !$past(spi_cs, 2) && !$past(spi_cs, 3)) |-> !spi_miso);

  a_r4_header_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |-> !spi_miso);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |=> $stable(reg_addr));

endmodule

bind spi_regslave spi_regslave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs     (spi_cs),
  .spi_miso   (spi_miso),
  .reg_rd_stb (reg_rd_stb),
  .reg_wr_stb (reg_wr_stb),
  .reg_addr   (reg_addr)
);

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, reg_wr_stb, reg_rd_stb;
  logic [5:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic [23:0] mem [64];
  logic [29:0] exp_q[$];
  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, exp_wr = 0, exp_rd = 0;
  bit done = 0;
  localparam int HALF = 6;

  always #2.5 clk = ~clk;

  spi_regslave u_spi_regslave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wr_stb(reg_wr_stb), .reg_wdata(reg_wdata),
    .reg_rd_stb(reg_rd_stb), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_rd_stb) rd_cnt++;
    if (rst_n && reg_wr_stb) begin
      wr_cnt++;
      if (exp_q.size() == 0) begin
        chk("R5 unexpected write", {2'b0, reg_addr, reg_wdata}, 32'hFFFF_FFFF);
      end else begin
        logic [29:0] e;
        e = exp_q.pop_front();
        chk("R2 write addr/data", {2'b0, reg_addr, reg_wdata}, {2'b0, e});
        mem[e[29:24]] = e[23:0];
      end
    end
  end

  task automatic frame(input logic [31:0] w, input int n, output logic [31:0] got);
    got = '0;
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_mosi = (i < 32) ? w[31-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      if (i < 32) got[31-i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs = 1'b0;
    spi_mosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [23:0] d, input logic spare);
    logic [31:0] g;
    exp_q.push_back({a, d});
    exp_wr++;
    frame({1'b1, a, spare, d}, 32, g);
    chk("R2 write count", wr_cnt, exp_wr);
    chk("R7 no read on write", rd_cnt, exp_rd);
  endtask

  task automatic do_read(input logic [5:0] a);
    logic [31:0] g;
    logic [23:0] e;
    e = mem[a];
    exp_rd++;
    frame({1'b0, a, 25'h0}, 32, g);
    chk("R3 read data", {8'h0, g[23:0]}, {8'h0, e});
    chk("R4 header bits zero", {24'h0, g[31:24]}, 32'h0);
    chk("R7 read count, no write", {rd_cnt[15:0], wr_cnt[15:0]}, {exp_rd[15:0], exp_wr[15:0]});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 24'(i * 7919 + 24'h10_0000);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 miso reset", spi_miso, 0);
    chk("R1 wr_stb reset", reg_wr_stb, 0);
    chk("R1 rd_stb reset", reg_rd_stb, 0);

    do_write(6'd5, 24'hABCDEF, 1'b0);
    do_read(6'd5);
    do_write(6'd63, 24'hFFFFFF, 1'b0);
    do_write(6'd0, 24'h000001, 1'b0);
    do_read(6'd63);
    do_read(6'd0);
    do_read(6'd42);

    // R6: spare bit set
    do_write(6'd10, 24'h123456, 1'b1);
    do_read(6'd10);

    // R5: short and long write frames discarded
    begin
      logic [31:0] g;
      frame({1'b1, 6'd20, 1'b0, 24'h55AA55}, 31, g);
      chk("R5 short frame no write", wr_cnt, exp_wr);
      frame({1'b1, 6'd20, 1'b0, 24'h55AA55}, 33, g);
      chk("R5 long frame no write", wr_cnt, exp_wr);
    end
    do_read(6'd20);

    // R8: SCLK activity without chip select
    spi_mosi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      chk("R4 miso idle", spi_miso, 0);
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    spi_mosi = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 no strobes outside frame", {rd_cnt[15:0], wr_cnt[15:0]}, {exp_rd[15:0], exp_wr[15:0]});
    do_write(6'd33, 24'h800001, 1'b0);
    do_read(6'd33);

    chk("R2 all expected writes seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule